// File: doc/BRIEF.md
# DMA Page-Extended Address Generator

This block forms the physical memory address for a single DMA channel while a transfer runs. A 16-bit current-address counter is combined with an 8-bit page register. An optional 8-bit high-page register extends the address to 32 bits. A second 16-bit register holds the transfer count. A step pulse advances the address and uses up one transfer. When the count runs out, a terminal-count flag rises and further steps are ignored until the count is programmed again.

The compile-time parameter `WORD_CH` selects the channel type. A byte channel puts the counter directly on address bits 15:0. A word channel moves one 16-bit word per step: the counter is shifted up one bit, page bit 0 is dropped and address bit 0 is held at zero. By default the counter wraps inside its 64 KB (byte) or 128 KB (word) page, and the address stays below 16 MB. Writing the high-page register as the last step of setup does two things: it puts that register on address bits 31:24, and it lets the counter carry into the page bits. Carries are applied to a working copy of the page, so the value programmed into the page register can still be read back unchanged.

Top module: `dma_pagex_agen`

## Requirements
- R1: On a byte channel the address is {bits 31:24, page[7:0], counter[15:0]}. Each accepted step adds one to the counter.
- R2: On a word channel the address is {bits 31:24, page[7:1], counter[15:0], 1'b0}. Page bit 0 has no effect on the address, and address bit 0 is always zero.
- R3: When the extension is off, a counter step from 0xFFFF goes to 0x0000 and the page bits do not change. Address bits 31:24 read zero.
- R4: Writing the high page (select code 5) turns the extension on and reloads the working page from the programmed page. Bits 31:24 then show the high page. A counter step from 0xFFFF adds one to the combined {high page, page} value on a byte channel and two on a word channel.
- R5: Writing address low (select 0), address high (select 1) or page (select 4) turns the extension off.
- R6: The count register (low byte select 2, high byte select 3) holds transfers minus one. Terminal count rises on the step that takes the count from 0x0000 to 0xFFFF. A count of 0xFFFF therefore allows 65536 steps, which is 128 KB on a word channel.
- R7: Once terminal count is set, the remaining count reads 0xFFFF and steps change neither the address nor the count. Writing either count byte clears terminal count.
- R8: The page readback output always shows the value last written with select 4, even after carries into the working page.
- R9: A write in the same cycle as a step takes priority, and that step is dropped. Writes with select codes 6 and 7 have no effect.
- R10: After reset the address, page readback, remaining count and terminal count are all zero, and the extension is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 8 | Write data byte |
| step | input | 1 | Advance one transfer |
| addr | output | 32 | Physical byte address |
| tc | output | 1 | Terminal count reached |
| remaining | output | 16 | Current count register |
| page_rb | output | 8 | Programmed page readback |

## Verification
The bench checks the counter rollover from 0xFFFF in both modes, with the extension on and off. A design that carries without the extension would move to the next page. One that never carries would trap a long transfer in its page. The bench also checks the carry from page 0xFF into the high page. It sweeps count values with a start address close to the wrap point, so an off-by-one terminal count or a missing wrap shows up as a wrong address or an early or late flag. It covers the full 65536-step word transfer, page readback after a carry, a write colliding with a step, and unused select codes, each of which catches a design that lets the wrong source win.

// File: rtl/dma_pagex_pkg.sv
package dma_pagex_pkg;
  localparam int CNT_W = 16;
  localparam int PG_W  = 8;
  localparam int ADR_W = 2 * PG_W + CNT_W;

  typedef enum logic [2:0] {
    SEL_ADR_LO = 3'd0,
    SEL_ADR_HI = 3'd1,
    SEL_CNT_LO = 3'd2,
    SEL_CNT_HI = 3'd3,
    SEL_PAGE   = 3'd4,
    SEL_HIPAGE = 3'd5
  } reg_sel_e;

  function automatic logic [ADR_W-1:0] compose_addr(
    input logic            word,
    input logic            ext,
    input logic [PG_W-1:0] hi,
    input logic [PG_W-1:0] pg,
    input logic [CNT_W-1:0] cnt);
    logic [PG_W-1:0] top;
    top = ext ? hi : '0;
    if (word) compose_addr = {top, pg[PG_W-1:1], cnt, 1'b0};
    else      compose_addr = {top, pg, cnt};
  endfunction

  function automatic logic [2*PG_W-1:0] bump_page(
    input logic              word,
    input logic [2*PG_W-1:0] hp);
    bump_page = word ? hp + 2 : hp + 1;
  endfunction
endpackage

// File: rtl/dma_pagex_addr.sv
module dma_pagex_addr
  import dma_pagex_pkg::*;
#(
  parameter bit WORD_CH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_alo,
  input  logic             wr_ahi,
  input  logic             wr_pg,
  input  logic             wr_hpg,
  input  logic [PG_W-1:0]  wdata,
  input  logic             advance,
  output logic [CNT_W-1:0] cur,
  output logic [PG_W-1:0]  wpage,
  output logic [PG_W-1:0]  whi,
  output logic             ext,
  output logic [PG_W-1:0]  page_prog
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic rollover;
  assign rollover = advance && (cur == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0; wpage <= '0; whi <= '0; ext <= 1'b0; page_prog <= '0;
    end else begin
      if (wr_alo) begin cur[PG_W-1:0] <= wdata; ext <= 1'b0; end
      if (wr_ahi) begin cur[CNT_W-1:PG_W] <= wdata; ext <= 1'b0; end
      if (wr_pg) begin
        page_prog <= wdata; wpage <= wdata; ext <= 1'b0;
      end
      if (wr_hpg) begin
        whi <= wdata; wpage <= page_prog; ext <= 1'b1;
      end
      if (advance) begin
        cur <= cur + 1'b1;
        if (rollover && ext) {whi, wpage} <= bump_page(WORD_CH, {whi, wpage});
      end
    end
  end

  AST_WRAP_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !ext) |=> ($stable(wpage) && $stable(whi))); // R3
  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (cur == $past(cur) + 1'b1)); // R1
  AST_PAGE_RB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> $stable(page_prog)); // R8
  AST_EXT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && ext) |=> ({whi, wpage} != $past({whi, wpage}))); // R4
endmodule

// File: rtl/dma_pagex_count.sv
module dma_pagex_count
  import dma_pagex_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_clo,
  input  logic             wr_chi,
  input  logic [PG_W-1:0]  wdata,
  input  logic             advance,
  output logic [CNT_W-1:0] count,
  output logic             tc_flag
);
  logic underflow;
  assign underflow = advance && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0; tc_flag <= 1'b0;
    end else begin
      if (wr_clo) begin count[PG_W-1:0] <= wdata; tc_flag <= 1'b0; end
      if (wr_chi) begin count[CNT_W-1:PG_W] <= wdata; tc_flag <= 1'b0; end
      if (advance) begin
        count <= count - 1'b1;
        if (underflow) tc_flag <= 1'b1;
      end
    end
  end

  AST_TC_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (tc_flag && count == '1)); // R6
  AST_TC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_flag && !wr_clo && !wr_chi) |=> (tc_flag && $stable(count))); // R7
  AST_NO_EARLY_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && count != '0) |=> !tc_flag); // R6
endmodule

// File: rtl/dma_pagex_agen.sv
module dma_pagex_agen
  import dma_pagex_pkg::*;
#(
  parameter bit WORD_CH = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        step,
  output logic [31:0] addr,
  output logic        tc,
  output logic [15:0] remaining,
  output logic [7:0]  page_rb
);
  localparam int NSEL = 6;

  logic [NSEL-1:0]  wr_hit;
  logic             any_write;
  logic             advance;
  logic [CNT_W-1:0] cur;
  logic [PG_W-1:0]  wpage, whi;
  logic             ext;

  for (genvar g = 0; g < NSEL; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_sel == 3'(g));
  end
  assign any_write = |wr_hit;
  assign advance   = step && !tc && !any_write;

  dma_pagex_addr #(.WORD_CH(WORD_CH)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .wr_alo(wr_hit[SEL_ADR_LO]), .wr_ahi(wr_hit[SEL_ADR_HI]),
    .wr_pg(wr_hit[SEL_PAGE]), .wr_hpg(wr_hit[SEL_HIPAGE]),
    .wdata(wr_data), .advance(advance),
    .cur(cur), .wpage(wpage), .whi(whi), .ext(ext), .page_prog(page_rb)
  );

  dma_pagex_count u_cnt (
    .clk(clk), .rst_n(rst_n),
    .wr_clo(wr_hit[SEL_CNT_LO]), .wr_chi(wr_hit[SEL_CNT_HI]),
    .wdata(wr_data), .advance(advance),
    .count(remaining), .tc_flag(tc)
  );

  assign addr = compose_addr(WORD_CH, ext, whi, wpage, cur);

  AST_LOW16MB: assert property (@(posedge clk) disable iff (!rst_n)
    !ext |-> (addr[31:24] == 8'h00)); // R3
  AST_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[SEL_ADR_LO] || wr_hit[SEL_ADR_HI] || wr_hit[SEL_PAGE]) |=> !ext); // R5
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && any_write && !wr_hit[SEL_CNT_LO] && !wr_hit[SEL_CNT_HI]) |=> $stable(remaining)); // R9
  if (WORD_CH) begin : g_word_chk
    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      addr[0] == 1'b0); // R2
  end
endmodule

// File: tb/test_dma_pagex_agen.sv
module test_dma_pagex_agen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic step = 1'b0;
  logic [31:0] addr_b, addr_w;
  logic tc_b, tc_w;
  logic [15:0] rem_b, rem_w;
  logic [7:0] pg_b, pg_w;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dma_pagex_agen #(.WORD_CH(1'b0)) i_dma_pagex_agen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .step(step), .addr(addr_b), .tc(tc_b), .remaining(rem_b), .page_rb(pg_b));
  dma_pagex_agen #(.WORD_CH(1'b1)) i_dma_pagex_agen_w (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .step(step), .addr(addr_w), .tc(tc_w), .remaining(rem_w), .page_rb(pg_w));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic steps(input int k);
    repeat (k) begin @(negedge clk); step = 1'b1; end
    @(negedge clk); step = 1'b0;
  endtask

  task automatic set_cnt(input logic [15:0] c);
    wr(3'd2, c[7:0]); wr(3'd3, c[15:8]);
  endtask

  task automatic set_adr(input logic [15:0] a);
    wr(3'd0, a[7:0]); wr(3'd1, a[15:8]);
  endtask

  function automatic logic [31:0] exp_byte(input logic [7:0] pg, input logic [15:0] c);
    return {8'h00, pg, c};
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] pg, input logic [15:0] c);
    return (32'(pg >> 1) << 17) | (32'(c) << 1);
  endfunction

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(addr_b, 32'h0, "R10 addr"); chk({31'b0, tc_b}, 32'h0, "R10 tc");
    chk({16'h0, rem_b}, 32'h0, "R10 remaining"); chk({24'h0, pg_b}, 32'h0, "R10 page_rb");

    // R1 / R2 composition
    set_cnt(16'hFFFF); set_adr(16'h1234); wr(3'd4, 8'h57);
    chk(addr_b, exp_byte(8'h57, 16'h1234), "R1 byte compose");
    chk(addr_w, exp_word(8'h57, 16'h1234), "R2 word compose page bit0 ignored");
    steps(1);
    chk(addr_b, exp_byte(8'h57, 16'h1235), "R1 byte step");
    chk(addr_w, exp_word(8'h57, 16'h1235), "R2 word step");

    // R3 wrap without extension
    wr(3'd5, 8'h9A); wr(3'd4, 8'h56); set_adr(16'hFFFF);
    chk(addr_w, exp_word(8'h56, 16'hFFFF), "R5 word top zero after page write");
    chk({24'h0, addr_b[31:24]}, 32'h0, "R5 ext off after page write");
    steps(1);
    chk(addr_b, exp_byte(8'h56, 16'h0000), "R3 byte wraps in page");
    chk(addr_w, exp_word(8'h56, 16'h0000), "R3 word wraps in page");

    // R4 extension carry
    set_cnt(16'hFFFF); set_adr(16'hFFFF); wr(3'd4, 8'h56); wr(3'd5, 8'h9A);
    chk(addr_b, 32'h9A56FFFF, "R4 high page on top bits");
    steps(1);
    chk(addr_b, 32'h9A570000, "R4 byte carry into page");
    chk(addr_w, 32'h9A580000, "R4 word carry into page");
    chk({24'h0, pg_b}, 32'h56, "R8 page readback byte");
    chk({24'h0, pg_w}, 32'h56, "R8 page readback word");
    wr(3'd4, 8'hFF); wr(3'd5, 8'h01); set_adr(16'hFFFF); wr(3'd5, 8'h01);
    steps(1);
    chk(addr_b, 32'h02000000, "R4 byte carry into high page");
    chk(addr_w, 32'h02000000, "R4 word carry into high page");

    // R9 write beats step, unused selects
    set_cnt(16'h0100); wr(3'd4, 8'h20); set_adr(16'h0005);
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h40; step = 1'b1;
    @(negedge clk); wr_en = 1'b0; step = 1'b0;
    chk(addr_b, exp_byte(8'h20, 16'h0040), "R9 write wins over step");
    chk({16'h0, rem_b}, 32'h0100, "R9 step dropped count");
    wr(3'd6, 8'hAA); wr(3'd7, 8'h55);
    chk(addr_b, exp_byte(8'h20, 16'h0040), "R9 unused select addr");
    chk({16'h0, rem_b}, 32'h0100, "R9 unused select count");
    chk({24'h0, pg_b}, 32'h20, "R9 unused select page");

    // R6 / R7 sweep of counts near the wrap point
    for (int n = 0; n < 48; n++) begin
      set_cnt(16'(n)); wr(3'd4, 8'h3C); set_adr(16'hFFF0);
      if (n > 0) steps(n);
      chk({31'b0, tc_b}, 32'h0, $sformatf("R6 no early tc n=%0d", n));
      steps(1);
      chk({31'b0, tc_b}, 32'h1, $sformatf("R6 tc n=%0d", n));
      chk({16'h0, rem_b}, 32'hFFFF, $sformatf("R7 remaining n=%0d", n));
      chk(addr_b, exp_byte(8'h3C, 16'hFFF0 + 16'(n + 1)), $sformatf("R3 sweep addr n=%0d", n));
      steps(2);
      chk(addr_b, exp_byte(8'h3C, 16'hFFF0 + 16'(n + 1)), $sformatf("R7 step ignored n=%0d", n));
      chk({16'h0, rem_b}, 32'hFFFF, $sformatf("R7 count held n=%0d", n));
    end
    set_cnt(16'h0003);
    chk({31'b0, tc_b}, 32'h0, "R7 count write clears tc");

    // R6 full 65536-step transfer with extension
    set_cnt(16'hFFFF); wr(3'd4, 8'h10); set_adr(16'h0000); wr(3'd5, 8'h00);
    chk(addr_w, 32'h00100000, "R6 word start");
    steps(65535);
    chk({31'b0, tc_w}, 32'h0, "R6 word no tc at 65535");
    chk({16'h0, rem_w}, 32'h0, "R6 word count zero");
    steps(1);
    chk({31'b0, tc_w}, 32'h1, "R6 word tc at 65536");
    chk(addr_w, 32'h00120000, "R6 word moved 128K");
    chk(addr_b, 32'h00110000, "R6 byte moved 64K");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule